// File: doc/BRIEF.md
# Fractional-N Divide-Ratio Controller

This block sits in the feedback path of a fractional-N synthesizer and runs at the oscillator clock rate. It counts clock cycles and emits a one-clock pulse at the end of every divider cycle. A small accumulator adds a programmed fractional step each cycle and wraps at a selectable modulus of 5 or 8. When the accumulator wraps, the cycle that follows is one clock longer. Over a full accumulator period the mean division ratio is therefore the integer ratio plus the step divided by the modulus.

A configuration word holds the integer ratio, the fractional step, the modulus select and a compensation gain. It is captured on a load strobe and held pending. It takes effect only at the next cycle boundary, so the output never takes a phase step. At every boundary the block opens a compensation window exactly 128 clocks wide. During that window it presents the gain multiplied by the accumulator value, which a downstream current DAC uses to cancel the fractional phase ripple. Dropping the enable parks the divider. Raising the enable again restarts the divider from a known phase, so it realigns with the reference divider.

Top module: `fracn_divctl`

## Requirements
- R1: After reset, and for as long as `en` is low, `div_pulse` and `comp_win` are 0 and `comp_code` is 0; `acc_out` reads 0 after reset.
- R2: A loaded ratio below 512 is raised to 512, so the shortest divider cycle is 512 clocks.
- R3: Each divider cycle ends with `div_pulse` high for exactly one clock. With no accumulator wrap, consecutive pulses are N clocks apart.
- R4: At each pulse that is not a reload, the accumulator takes (acc + step) mod Q, and `acc_out` shows the new value from the pulse clock onward. `mod5_in` = 1 selects Q = 5; `mod5_in` = 0 selects Q = 8.
- R5: When the accumulator wraps at a pulse, the interval up to the next pulse is N+1. Over Q consecutive intervals the total is Q·N + step.
- R6: With Q = 5, a loaded step of 5 or more is reduced by 5 (7 acts as 2).
- R7: A word loaded mid-cycle leaves the current interval unchanged. It is applied at the next pulse, where the accumulator restarts at 0 and the following interval is the new N.
- R8: `comp_win` rises together with `div_pulse` and stays high for exactly 128 clocks.
- R9: While `comp_win` is high, `comp_code` equals the 8-bit gain times the accumulator value of that cycle. Outside the window `comp_code` is 0.
- R10: While `en` is low, no pulse is produced. The first clock edge that samples `en` high clears the accumulator and starts a cycle of N clocks, so the first pulse is visible N+1 clocks after `en` is driven high, and it reports the step as its accumulator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks the divider |
| load | input | 1 | Capture strobe for the configuration word |
| ratio_in | input | 16 | Integer divide ratio N |
| step_in | input | 3 | Fractional step added per cycle |
| mod5_in | input | 1 | Modulus select: 1 gives 5, 0 gives 8 |
| gain_in | input | 8 | Compensation gain multiplied by the accumulator |
| div_pulse | output | 1 | One-clock pulse at each cycle end |
| acc_out | output | 3 | Current accumulator contents |
| comp_win | output | 1 | 128-clock compensation window |
| comp_code | output | 11 | Compensation amplitude code during the window |

## Verification
The bench targets the interval right after a wrap. A design that applies the extra clock to the wrong cycle still gives the correct average, but its interval sequence is shifted. The bench also loads a word mid-cycle and checks that the running interval keeps its old length; a design that reloads early shows a shortened or stretched cycle. It loads a step of 7 with modulus 5, where a design without the reduction would produce a double wrap or an accumulator value of 5 or more. Finally it checks the exact restart latency after the enable returns, and a window that is one clock short or long.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int unsigned MOD_SHORT = 5;
  localparam int unsigned MOD_LONG  = 8;
endpackage

// File: rtl/fracn_cfg.sv
module fracn_cfg
  import fracn_pkg::*;
#(
  parameter int unsigned NW   = 16,
  parameter int unsigned FW   = 3,
  parameter int unsigned DW   = 8,
  parameter int unsigned NMIN = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [NW-1:0] ratio_i,
  input  logic [FW-1:0] step_i,
  input  logic          mod5_i,
  input  logic [DW-1:0] gain_i,
  input  logic          apply_i,
  output logic [NW-1:0] nxt_ratio_o,
  output logic [FW-1:0] nxt_step_o,
  output logic          nxt_mod5_o,
  output logic [DW-1:0] nxt_gain_o,
  output logic          act_mod5_o,
  output logic          pend_o
);
  logic [NW-1:0] p_ratio_q, a_ratio_q, ratio_fix;
  logic [FW-1:0] p_step_q, a_step_q, step_fix;
  logic [DW-1:0] p_gain_q, a_gain_q;
  logic          p_mod5_q, a_mod5_q, pend_q, pend_d;

  always_comb begin
    ratio_fix = (ratio_i < NW'(NMIN)) ? NW'(NMIN) : ratio_i;
    step_fix  = (mod5_i && (step_i >= FW'(MOD_SHORT))) ? step_i - FW'(MOD_SHORT) : step_i;
    pend_d    = pend_q;
    if (load_i)       pend_d = 1'b1;
    else if (apply_i) pend_d = 1'b0;
    nxt_ratio_o = pend_q ? p_ratio_q : a_ratio_q;
    nxt_step_o  = pend_q ? p_step_q  : a_step_q;
    nxt_mod5_o  = pend_q ? p_mod5_q  : a_mod5_q;
    nxt_gain_o  = pend_q ? p_gain_q  : a_gain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      p_ratio_q <= NW'(NMIN);
      p_step_q  <= '0;
      p_mod5_q  <= 1'b0;
      p_gain_q  <= '0;
      a_ratio_q <= NW'(NMIN);
      a_step_q  <= '0;
      a_mod5_q  <= 1'b0;
      a_gain_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (load_i) begin
        p_ratio_q <= ratio_fix;
        p_step_q  <= step_fix;
        p_mod5_q  <= mod5_i;
        p_gain_q  <= gain_i;
      end
      if (apply_i) begin
        a_ratio_q <= nxt_ratio_o;
        a_step_q  <= nxt_step_o;
        a_mod5_q  <= nxt_mod5_o;
        a_gain_q  <= nxt_gain_o;
      end
    end
  end

  assign pend_o     = pend_q;
  assign act_mod5_o = a_mod5_q;
endmodule

// File: rtl/fracn_acc.sv
module fracn_acc
  import fracn_pkg::*;
#(
  parameter int unsigned FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          adv_i,
  input  logic [FW-1:0] step_i,
  input  logic          mod5_i,
  output logic [FW-1:0] acc_o,
  output logic [FW-1:0] acc_nxt_o,
  output logic          carry_o
);
  localparam logic [FW:0] QS = (FW+1)'(MOD_SHORT);
  localparam logic [FW:0] QL = (FW+1)'(MOD_LONG);

  logic [FW-1:0] acc_q, acc_d;
  logic [FW:0]   sum, wrapped;
  logic          wrap;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, step_i};
    wrap    = mod5_i ? (sum >= QS) : (sum >= QL);
    wrapped = sum - (mod5_i ? QS : QL);
    acc_d   = acc_q;
    if (clear_i)    acc_d = '0;
    else if (adv_i) acc_d = wrap ? wrapped[FW-1:0] : sum[FW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc_q <= '0;
    else if (clear_i || adv_i) acc_q <= acc_d;
  end

  assign acc_o     = acc_q;
  assign acc_nxt_o = acc_d;
  assign carry_o   = wrap;
endmodule

// File: rtl/fracn_cnt.sv
module fracn_cnt #(
  parameter int unsigned NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [NW-1:0] preload_i,
  output logic          run_o,
  output logic          start_o,
  output logic          term_o
);
  logic [NW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    run_d   = run_q;
    cnt_d   = cnt_q;
    start_o = en_i && !run_q;
    term_o  = en_i && run_q && (cnt_q == '0);
    if (!en_i) begin
      run_d = 1'b0;
    end else if (start_o || term_o) begin
      run_d = 1'b1;
      cnt_d = preload_i;
    end else begin
      cnt_d = cnt_q - NW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (en_i) cnt_q <= cnt_d;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/fracn_win.sv
module fracn_win #(
  parameter int unsigned WIN = 128,
  parameter int unsigned CW  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          fire_i,
  input  logic [CW-1:0] code_i,
  output logic          win_o,
  output logic [CW-1:0] code_o
);
  localparam int unsigned WCW = $clog2(WIN);

  logic [WCW-1:0] wc_q, wc_d;
  logic           win_q, win_d;
  logic [CW-1:0]  code_q, code_d;

  always_comb begin
    win_d  = win_q;
    wc_d   = wc_q;
    code_d = code_q;
    if (!en_i) begin
      win_d  = 1'b0;
      code_d = '0;
    end else if (fire_i) begin
      win_d  = 1'b1;
      wc_d   = WCW'(WIN - 1);
      code_d = code_i;
    end else if (win_q) begin
      if (wc_q == '0) begin
        win_d  = 1'b0;
        code_d = '0;
      end else begin
        wc_d = wc_q - WCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      wc_q   <= '0;
      code_q <= '0;
    end else begin
      win_q  <= win_d;
      wc_q   <= wc_d;
      code_q <= code_d;
    end
  end

  assign win_o  = win_q;
  assign code_o = code_q;
endmodule

// File: rtl/fracn_divctl.sv
module fracn_divctl #(
  parameter int unsigned NW   = 16,
  parameter int unsigned FW   = 3,
  parameter int unsigned DW   = 8,
  parameter int unsigned NMIN = 512,
  parameter int unsigned WIN  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [NW-1:0]    ratio_in,
  input  logic [FW-1:0]    step_in,
  input  logic             mod5_in,
  input  logic [DW-1:0]    gain_in,
  output logic             div_pulse,
  output logic [FW-1:0]    acc_out,
  output logic             comp_win,
  output logic [DW+FW-1:0] comp_code
);
  localparam int unsigned CW = DW + FW;

  logic          rst_meta, rst_s;
  logic [NW-1:0] nxt_ratio, preload;
  logic [FW-1:0] nxt_step, acc_nxt;
  logic [DW-1:0] nxt_gain;
  logic          nxt_mod5, mod5_act, pend, carry;
  logic          run, start, term, fresh, adv, pulse_q;
  logic [NW:0]   len, len_m1;
  logic [CW-1:0] code_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  always_comb begin
    fresh   = start || (term && pend);
    adv     = term && !pend;
    len     = {1'b0, nxt_ratio} + (fresh ? '0 : (NW+1)'(carry));
    len_m1  = len - (NW+1)'(1);
    preload = len_m1[NW-1:0];
    code_in = CW'(nxt_gain) * CW'(acc_nxt);
  end

  fracn_cfg #(.NW(NW), .FW(FW), .DW(DW), .NMIN(NMIN)) u_cfg (
    .clk(clk), .rst_n(rst_s), .load_i(load), .ratio_i(ratio_in), .step_i(step_in),
    .mod5_i(mod5_in), .gain_i(gain_in), .apply_i(fresh), .nxt_ratio_o(nxt_ratio),
    .nxt_step_o(nxt_step), .nxt_mod5_o(nxt_mod5), .nxt_gain_o(nxt_gain),
    .act_mod5_o(mod5_act), .pend_o(pend)
  );

  fracn_acc #(.FW(FW)) u_acc (
    .clk(clk), .rst_n(rst_s), .clear_i(fresh), .adv_i(adv), .step_i(nxt_step),
    .mod5_i(nxt_mod5), .acc_o(acc_out), .acc_nxt_o(acc_nxt), .carry_o(carry)
  );

  fracn_cnt #(.NW(NW)) u_cnt (
    .clk(clk), .rst_n(rst_s), .en_i(en), .preload_i(preload),
    .run_o(run), .start_o(start), .term_o(term)
  );

  fracn_win #(.WIN(WIN), .CW(CW)) u_win (
    .clk(clk), .rst_n(rst_s), .en_i(en), .fire_i(term), .code_i(code_in),
    .win_o(comp_win), .code_o(comp_code)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) pulse_q <= 1'b0;
    else        pulse_q <= term;
  end

  assign div_pulse = pulse_q;
endmodule

// File: rtl/fracn_divctl_chk.sv
module fracn_divctl_chk #(
  parameter int unsigned FW  = 3,
  parameter int unsigned CW  = 11,
  parameter int unsigned WIN = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          div_pulse,
  input logic [FW-1:0] acc_out,
  input logic          comp_win,
  input logic [CW-1:0] comp_code,
  input logic          mod5_act,
  input logic          run
);
  logic [15:0] win_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_len <= '0;
    else if (comp_win) win_len <= win_len + 16'd1;
    else               win_len <= '0;
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !div_pulse);

  // R4
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod5_act |-> (acc_out < FW'(5)));

  // R4
  acc_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_out) |-> (div_pulse || $rose(run)));

  // R8
  win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(comp_win) |-> div_pulse);

  // R8
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(comp_win) && $past(en)) |-> (win_len == 16'(WIN)));

  // R9
  code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_win |-> (comp_code == '0));
endmodule

bind fracn_divctl fracn_divctl_chk #(.FW(FW), .CW(CW), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .div_pulse(div_pulse), .acc_out(acc_out),
  .comp_win(comp_win), .comp_code(comp_code), .mod5_act(mod5_act), .run(run)
);

// File: tb/fracn_divctl_test.sv
module fracn_divctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, en, load, mod5_in;
  logic [15:0] ratio_in;
  logic [2:0]  step_in;
  logic [7:0]  gain_in;
  logic        div_pulse, comp_win;
  logic [2:0]  acc_out;
  logic [10:0] comp_code;

  int total, bad, cyc, last_cyc, period;

  fracn_divctl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .ratio_in(ratio_in),
    .step_in(step_in), .mod5_in(mod5_in), .gain_in(gain_in), .div_pulse(div_pulse),
    .acc_out(acc_out), .comp_win(comp_win), .comp_code(comp_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_pulse();
    int n;
    n = 0;
    @(negedge clk);
    while (!div_pulse && n < 70000) begin
      @(negedge clk);
      n++;
    end
    if (!div_pulse) check("pulse timeout", 0, 1);
    period   = cyc - last_cyc;
    last_cyc = cyc;
  endtask

  task automatic do_load(input int n, input int st, input bit m5, input int g);
    ratio_in = 16'(n);
    step_in  = 3'(st);
    mod5_in  = m5;
    gain_in  = 8'(g);
    load     = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic t_reset();
    int pulses;
    check("R1 pulse at reset", int'(div_pulse), 0);
    check("R1 acc at reset", int'(acc_out), 0);
    check("R1 window at reset", int'(comp_win), 0);
    check("R1 code at reset", int'(comp_code), 0);
    pulses = 0;
    repeat (700) begin
      @(negedge clk);
      if (div_pulse || comp_win) pulses++;
    end
    check("R1 idle while disabled", pulses, 0);
  endtask

  task automatic t_start();
    int s;
    @(negedge clk);
    en = 1'b1;
    s  = cyc;
    next_pulse();
    check("R10 first pulse latency", cyc - s, 513);
    check("R10 first acc", int'(acc_out), 0);
    @(negedge clk);
    check("R3 pulse width", int'(div_pulse), 0);
    next_pulse();
    check("R3 integer interval", period, 512);
  endtask

  task automatic t_midload();
    do_load(700, 0, 1'b0, 0);
    next_pulse();
    check("R7 reload clears acc", int'(acc_out), 0);
    repeat (100) @(negedge clk);
    do_load(900, 0, 1'b0, 0);
    next_pulse();
    check("R7 current interval kept", period, 700);
    next_pulse();
    check("R7 new ratio applied", period, 900);
  endtask

  task automatic t_clamp();
    do_load(100, 0, 1'b0, 0);
    next_pulse();
    next_pulse();
    check("R2 ratio clamp", period, 512);
  endtask

  task automatic t_frac(input int n, input int st, input bit m5, input int eff, input string tag);
    int q, acc, carry, sum, tot;
    q = m5 ? 5 : 8;
    do_load(n, st, m5, 0);
    next_pulse();
    check({tag, " reload acc"}, int'(acc_out), 0);
    acc = 0; carry = 0; tot = 0;
    for (int k = 1; k <= 2*q; k++) begin
      next_pulse();
      check({tag, " interval"}, period, n + carry);
      if (k >= 2 && k <= q + 1) tot += period;
      sum   = acc + eff;
      carry = (sum >= q) ? 1 : 0;
      acc   = carry ? sum - q : sum;
      check({tag, " acc value"}, int'(acc_out), acc);
    end
    check("R5 average over Q", tot, q*n + eff);
  endtask

  task automatic t_window();
    int n;
    do_load(600, 3, 1'b0, 200);
    next_pulse();
    check("R9 window at reload", int'(comp_win), 1);
    check("R9 code at acc zero", int'(comp_code), 0);
    next_pulse();
    check("R8 window opens with pulse", int'(comp_win), 1);
    check("R9 code value", int'(comp_code), 600);
    n = 0;
    while (comp_win && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R8 window length", n, 128);
    check("R9 code after window", int'(comp_code), 0);
  endtask

  task automatic t_powerdown();
    int pulses, s;
    en = 1'b0;
    pulses = 0;
    repeat (1500) begin
      @(negedge clk);
      if (div_pulse || comp_win) pulses++;
    end
    check("R10 no pulse while parked", pulses, 0);
    en = 1'b1;
    s  = cyc;
    next_pulse();
    check("R10 restart latency", cyc - s, 601);
    check("R10 acc after restart", int'(acc_out), 3);
    check("R9 code after restart", int'(comp_code), 600);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; last_cyc = 0; period = 0;
    rst_n = 1'b0; en = 1'b0; load = 1'b0;
    ratio_in = '0; step_in = '0; mod5_in = 1'b0; gain_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_start();
    t_midload();
    t_clamp();
    t_frac(600, 3, 1'b0, 3, "R4");
    t_frac(520, 2, 1'b1, 2, "R5");
    t_frac(530, 7, 1'b1, 2, "R6");
    t_window();
    t_powerdown();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule